// File: doc/BRIEF.md
# Nibble-Pair Word Deserializer

This block rebuilds transmit samples that arrive split into two nibbles on a narrow bus. The bus is sampled on every rising clock edge, and that clock runs at twice the word rate. A sync line tells the block which nibble is which. A nibble sampled with sync low is taken as the upper half of a word. The next nibble sampled with sync high is taken as the lower half, and that cycle finishes the word. The finished word is held, shown on a 12-bit two's-complement output, and marked by a single-cycle valid strobe.

If sync stays low for longer than one cycle, the block keeps presenting the last finished word. It pulses valid once every two clocks, so the downstream word rate does not change. The sender can use this to feed a repeated value, such as zero, into a following filter.

A mode input selects one of two nibble widths:
- Full nibbles: 6 bits, forming 12-bit words.
- Narrow nibbles: 5 bits taken from the low bits of the bus, forming 10-bit words that are sign-extended to the 12-bit output.

An enable input gates the output word to zero. A flag reports misuse of the gain-select input while a word is being formed.

Top module: `nib_pair_deser`

## Requirements
- R1: While rst_n is low at a clock edge, the held word becomes 0 and valid_o and gain_err_o become 0. Any pending upper nibble is discarded, so a sync-high nibble right after reset produces no word.
- R2: With narrow_i=0, a nibble U sampled with sync_i=0 and then a nibble L sampled with sync_i=1 on the next edge produce word_o = {U[5:0], L[5:0]}. valid_o is 1 for exactly the cycle after that second edge.
- R3: With narrow_i=1, only bits [4:0] of each nibble are used, and bit 5 has no effect. The 10-bit value {U[4:0], L[4:0]} is sign-extended from its bit 9 to 12 bits.
- R4: While sync_i stays 0, the held word does not change. valid_o is 1 after the 2nd, 4th, 6th, ... consecutive low edge and 0 after the 1st, 3rd, 5th, ... low edge.
- R5: After several consecutive sync-low edges, the upper nibble of the next word is the one sampled on the last low edge.
- R6: A nibble sampled with sync_i=1 when no upper nibble is pending is ignored. This includes the second of two back-to-back high edges. valid_o stays 0 and word_o is unchanged.
- R7: While pass_en_i=0, word_o is 0 in the same cycle, and valid_o keeps pulsing as usual. When pass_en_i returns to 1, word_o shows the held word again.
- R8: gain_err_o is 1 in the cycle after an edge where gain_i=1 and a word is being formed, meaning sync_i=0 or an upper nibble is pending. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock, rising edge, twice the word rate |
| rst_n | input | 1 | Synchronous active-low reset |
| nib_i | input | 6 | Nibble bus |
| sync_i | input | 1 | Low marks the upper nibble, high marks the lower nibble |
| narrow_i | input | 1 | 1 selects 5-bit nibbles and 10-bit words |
| pass_en_i | input | 1 | 1 passes the held word, 0 forces word_o to zero |
| gain_i | input | 1 | Gain-select line that must stay low during transmit |
| word_o | output | 12 | Held word, two's complement |
| valid_o | output | 1 | One-cycle strobe per finished or repeated word |
| gain_err_o | output | 1 | Gain-select misuse flag |

## Verification
The assertions check, on every cycle, these behaviours:
- Gating forces word_o to zero.
- A pending upper nibble followed by sync high always yields a valid strobe.
- An orphan high nibble never does.
- The first low edge of a run never strobes.
- The held word stays put through low runs.
- Gain misuse during a low edge raises the flag.

Only the bench's sweeps can show that the assembled values are arithmetically right in both widths, including the sign extension and the ignored bit 5. The same holds for the exact alternating strobe cadence over a long low run, and for the choice of the last low nibble as the next upper half.

// File: rtl/nds_pkg.sv
// Shared definitions for the nibble-pair deserializer.
// Assumes: nibble-width choice is a single select line.
package nds_pkg;
    typedef enum logic {
        MODE_FULL   = 1'b0,
        MODE_NARROW = 1'b1
    } nds_mode_e;
endpackage

// File: rtl/nds_msn_latch.sv
// Captures the upper nibble on sync-low edges and tracks low-run parity.
// Emits a word-done pulse (lower nibble arriving with an upper one pending)
// and a repeat tick on every even-numbered consecutive low edge.
// Assumes: sync is sampled on the same edge as the nibble bus.
module nds_msn_latch #(
    parameter int NIB_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_i,
    input  logic [NIB_W-1:0] nib_i,
    output logic [NIB_W-1:0] msn_q,
    output logic             pend_q,
    output logic             done_o,
    output logic             rep_o
);
    logic low_odd_q;

    // Hold upper nibble, pending flag and low-run parity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msn_q     <= '0;
            pend_q    <= 1'b0;
            low_odd_q <= 1'b0;
        end else if (!sync_i) begin
            msn_q     <= nib_i;
            pend_q    <= 1'b1;
            low_odd_q <= ~low_odd_q;
        end else begin
            pend_q    <= 1'b0;
            low_odd_q <= 1'b0;
        end
    end

    // Decode this edge's event for the word holder.
    always_comb begin
        done_o = sync_i && pend_q;
        rep_o  = !sync_i && low_odd_q;
    end
endmodule

// File: rtl/nds_word_hold.sv
// Assembles the word from the upper and lower nibbles, sign-extends the
// narrow form, and holds the result. Drives a one-cycle valid strobe.
// Assumes: done and rep are never high on the same edge.
module nds_word_hold
    import nds_pkg::*;
#(
    parameter int NIB_W    = 6,
    parameter int NARROW_W = 5,
    parameter int OUT_W    = 2 * NIB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             narrow_i,
    input  logic [NIB_W-1:0] msn_i,
    input  logic [NIB_W-1:0] lsn_i,
    input  logic             done_i,
    input  logic             rep_i,
    output logic [OUT_W-1:0] held_q,
    output logic             valid_q
);
    localparam int NW  = 2 * NARROW_W;
    localparam int PAD = OUT_W - NW;

    logic [OUT_W-1:0] full_w;
    logic [NW-1:0]    short_w;
    logic [OUT_W-1:0] short_ext;
    logic [OUT_W-1:0] next_w;

    // Concatenate both forms of the word.
    always_comb begin
        full_w  = {msn_i, lsn_i};
        short_w = {msn_i[NARROW_W-1:0], lsn_i[NARROW_W-1:0]};
    end

    // Sign extension only when the narrow word is shorter than the output.
    generate
        if (PAD > 0) begin : g_ext
            assign short_ext = {{PAD{short_w[NW-1]}}, short_w};
        end else begin : g_noext
            assign short_ext = short_w;
        end
    endgenerate

    // Pick the word form from the mode.
    always_comb begin
        next_w = (nds_mode_e'(narrow_i) == MODE_NARROW) ? short_ext : full_w;
    end

    // Latch finished words and strobe valid on finish or repeat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            if (done_i) held_q <= next_w;
            valid_q <= done_i || rep_i;
        end
    end
endmodule

// File: rtl/nds_out_gate.sv
// Forces the output word to zero when passing is disabled and registers
// the gain-misuse flag.
// Assumes: pass enable is a level, applied without delay.
module nds_out_gate #(
    parameter int OUT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pass_en_i,
    input  logic [OUT_W-1:0] held_i,
    input  logic             gain_i,
    input  logic             sync_i,
    input  logic             pend_i,
    output logic [OUT_W-1:0] word_o,
    output logic             gain_err_o
);
    // Gate the held word onto the output.
    always_comb begin
        word_o = pass_en_i ? held_i : '0;
    end

    // Flag gain-select high while a word is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) gain_err_o <= 1'b0;
        else        gain_err_o <= gain_i && (!sync_i || pend_i);
    end
endmodule

// File: rtl/nib_pair_deser.sv
// Top of the nibble-pair deserializer: latch, word holder and output gate.
// Assumes: one clock domain at the nibble rate, synchronous active-low reset.
module nib_pair_deser #(
    parameter int NIB_W    = 6,
    parameter int NARROW_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NIB_W-1:0]   nib_i,
    input  logic               sync_i,
    input  logic               narrow_i,
    input  logic               pass_en_i,
    input  logic               gain_i,
    output logic [2*NIB_W-1:0] word_o,
    output logic               valid_o,
    output logic               gain_err_o
);
    localparam int OUT_W = 2 * NIB_W;

    logic [NIB_W-1:0] msn_q;
    logic             pend_q;
    logic             done_w;
    logic             rep_w;
    logic [OUT_W-1:0] held_q;

    nds_msn_latch #(.NIB_W(NIB_W)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (sync_i),
        .nib_i  (nib_i),
        .msn_q  (msn_q),
        .pend_q (pend_q),
        .done_o (done_w),
        .rep_o  (rep_w)
    );

    nds_word_hold #(.NIB_W(NIB_W), .NARROW_W(NARROW_W), .OUT_W(OUT_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .narrow_i (narrow_i),
        .msn_i    (msn_q),
        .lsn_i    (nib_i),
        .done_i   (done_w),
        .rep_i    (rep_w),
        .held_q   (held_q),
        .valid_q  (valid_o)
    );

    nds_out_gate #(.OUT_W(OUT_W)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .pass_en_i  (pass_en_i),
        .held_i     (held_q),
        .gain_i     (gain_i),
        .sync_i     (sync_i),
        .pend_i     (pend_q),
        .word_o     (word_o),
        .gain_err_o (gain_err_o)
    );
endmodule

// File: rtl/nds_checker.sv
// Cycle-level properties of the nibble-pair deserializer, bound to the top.
module nds_checker #(
    parameter int OUT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_i,
    input logic             pass_en_i,
    input logic             gain_i,
    input logic             pend_q,
    input logic [OUT_W-1:0] held_q,
    input logic [OUT_W-1:0] word_o,
    input logic             valid_o,
    input logic             gain_err_o
);
    p_gate_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pass_en_i |-> (word_o == '0));

    p_done_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_i && pend_q) |=> valid_o);

    p_orphan_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_i && !pend_q) |=> !valid_o);

    p_first_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_i && $past(sync_i)) |=> !valid_o);

    p_hold_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_i |=> $stable(held_q));

    p_gain_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_i && !sync_i) |=> gain_err_o);
endmodule

bind nib_pair_deser nds_checker #(.OUT_W(2*NIB_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_i     (sync_i),
    .pass_en_i  (pass_en_i),
    .gain_i     (gain_i),
    .pend_q     (pend_q),
    .held_q     (held_q),
    .word_o     (word_o),
    .valid_o    (valid_o),
    .gain_err_o (gain_err_o)
);

// File: tb/nib_pair_deser_tb.sv
module nib_pair_deser_tb;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  nib_i = '0;
    logic        sync_i = 1'b1;
    logic        narrow_i = 1'b0;
    logic        pass_en_i = 1'b1;
    logic        gain_i = 1'b0;
    logic [11:0] word_o;
    logic        valid_o;
    logic        gain_err_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    nib_pair_deser u_dut (
        .clk(clk), .rst_n(rst_n), .nib_i(nib_i), .sync_i(sync_i),
        .narrow_i(narrow_i), .pass_en_i(pass_en_i), .gain_i(gain_i),
        .word_o(word_o), .valid_o(valid_o), .gain_err_o(gain_err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one nibble and wait until just after the sampling edge.
    task automatic step(input logic [5:0] n, input logic s);
        nib_i  = n;
        sync_i = s;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [11:0] expect_word(input logic [5:0] u, input logic [5:0] l, input logic nar);
        logic [9:0] s10;
        if (!nar) return {u, l};
        s10 = {u[4:0], l[4:0]};
        return {{2{s10[9]}}, s10};
    endfunction

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<%0d cycles", cyc, WATCHDOG);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [11:0] last;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1 word", word_o, 12'h000);
        check("R1 valid", {11'b0, valid_o}, 12'h000);
        check("R1 gain_err", {11'b0, gain_err_o}, 12'h000);
        rst_n = 1'b1;
        // R1/R6: high nibble right after reset is ignored
        step(6'h2A, 1'b1);
        check("R1 no word after reset", {11'b0, valid_o}, 12'h000);
        check("R1 word stays zero", word_o, 12'h000);

        // R2: exhaustive full-width sweep
        for (int u = 0; u < 64; u++) begin
            for (int l = 0; l < 64; l++) begin
                step(6'(u), 1'b0);
                check("R2 no strobe on upper", {11'b0, valid_o}, 12'h000);
                step(6'(l), 1'b1);
                check("R2 strobe", {11'b0, valid_o}, 12'h001);
                check("R2 word", word_o, expect_word(6'(u), 6'(l), 1'b0));
            end
        end

        // R3: narrow sweep, bit 5 driven with junk
        narrow_i = 1'b1;
        for (int u = 0; u < 32; u++) begin
            for (int l = 0; l < 32; l++) begin
                logic [5:0] un = {1'(u ^ l), 5'(u)};
                logic [5:0] ln = {1'(l), 5'(l)};
                step(un, 1'b0);
                step(ln, 1'b1);
                check("R3 strobe", {11'b0, valid_o}, 12'h001);
                check("R3 word", word_o, expect_word(un, ln, 1'b1));
            end
        end
        narrow_i = 1'b0;

        // R4/R5: low run repeats the held word on even edges
        step(6'h15, 1'b0);
        step(6'h2B, 1'b1);
        last = expect_word(6'h15, 6'h2B, 1'b0);
        check("R4 setup word", word_o, last);
        for (int k = 1; k <= 5; k++) begin
            step(6'(k + 8), 1'b0);
            check("R4 cadence", {11'b0, valid_o}, (k % 2 == 0) ? 12'h001 : 12'h000);
            check("R4 held", word_o, last);
        end
        step(6'h07, 1'b1);
        check("R5 new word strobe", {11'b0, valid_o}, 12'h001);
        check("R5 last low is upper", word_o, expect_word(6'd13, 6'h07, 1'b0));
        last = word_o;

        // R6: second back-to-back high is orphaned
        step(6'h3F, 1'b1);
        check("R6 no strobe", {11'b0, valid_o}, 12'h000);
        check("R6 word unchanged", word_o, last);

        // R7: gating forces zero, strobes continue, word returns
        pass_en_i = 1'b0;
        #1;
        check("R7 gated immediately", word_o, 12'h000);
        step(6'h21, 1'b0);
        step(6'h12, 1'b1);
        check("R7 strobe while gated", {11'b0, valid_o}, 12'h001);
        check("R7 gated word", word_o, 12'h000);
        pass_en_i = 1'b1;
        #1;
        check("R7 word restored", word_o, expect_word(6'h21, 6'h12, 1'b0));

        // R8: gain misuse flag
        gain_i = 1'b1;
        step(6'h01, 1'b0);
        check("R8 flag on upper", {11'b0, gain_err_o}, 12'h001);
        step(6'h02, 1'b1);
        check("R8 flag on lower", {11'b0, gain_err_o}, 12'h001);
        step(6'h03, 1'b1);
        check("R8 idle high no flag", {11'b0, gain_err_o}, 12'h000);
        gain_i = 1'b0;
        step(6'h04, 1'b0);
        check("R8 gain low no flag", {11'b0, gain_err_o}, 12'h000);

        // R1: reset mid-word discards pending upper nibble
        rst_n = 1'b0;
        step(6'h04, 1'b0);
        check("R1 reset clears word", word_o, 12'h000);
        rst_n = 1'b1;
        step(6'h05, 1'b1);
        check("R1 pending discarded", {11'b0, valid_o}, 12'h000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule